// File: doc/BRIEF.md
# Serial Flash Clock and Select Strobe Generator

This block produces the serial clock and the active-low select lines that a serial flash master drives toward its devices. It runs from a fast reference clock. Two configuration words set it up. One holds the clock divisor, polarity, phase, select code and decoder mode. The other holds four 8-bit interval counts, all measured in reference cycles. A start pulse with a bit count runs one transfer. The block drops the select, waits a lead interval, issues the requested serial clock cycles, waits a trailing interval, and then keeps the select high for a minimum rest time before it takes a new start.

Both configuration words load only while the enable input is low. Transfers start only while it is high. A device-change gap is added to the rest interval only when the select pattern differs from the one used by the previous transfer. Shifting data, decoding commands and any bus interface belong to the surrounding controller.

Top module: `sflash_strobe_gen`

## Requirements
- R1: While clocking, successive changes of `sclk` are exactly H = div+1 reference cycles apart, so the serial period is 2*(div+1) cycles. The divisor `div` sits in `cfg_word[3:0]`.
- R2: Outside a transfer `sclk` rests at the polarity bit `cfg_word[4]`. A transfer of n bits makes exactly 2n changes of `sclk` and leaves it at that resting level.
- R3: The first `sclk` change comes `lead`+1 cycles after the cycle in which `csn` falls when the phase bit `cfg_word[5]` is 1. It comes `lead`+1+H cycles after that cycle when the phase bit is 0. `lead` is `dly_word[7:0]`.
- R4: With the decoder bit `cfg_word[6]` at 0, the select code `cfg_word[10:7]` names a device in its low two bits. During a transfer `csn` then has only that line low: device 0 gives 1110, device 1 gives 1101, device 2 gives 1011 and device 3 gives 0111.
- R5: With the decoder bit at 1, `csn` carries the 4-bit select code unchanged during a transfer.
- R6: `csn` returns to all ones `trail`+2H+3 cycles after the last `sclk` change when the phase is 0, and `trail`+3H+3 cycles after it when the phase is 1. `trail` is `dly_word[15:8]`.
- R7: After `csn` rises, `busy` stays high for `rest`+2H+1 more cycles when the select pattern equals that of the previous transfer, or when there was no previous transfer. `rest` is `dly_word[31:24]`.
- R8: When the select pattern differs from that of the previous transfer, the interval of R7 grows by `swap` cycles. `swap` is `dly_word[23:16]`.
- R9: Writes to either configuration word take effect only while `ctl_en` is 0. A write made while `ctl_en` is 1 changes nothing.
- R10: A start is accepted only when the block is not busy, `ctl_en` is 1 and the bit count is nonzero. Any other start pulse is ignored.
- R11: After reset `csn` is all ones, `busy` is 0, `idle` is 1 and `sclk` is 0. At all times `idle` is the inverse of `busy`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_en | input | 1 | Global enable; configuration loads only while low |
| cfg_we | input | 1 | Load strobe for `cfg_word` |
| cfg_word | input | 11 | Divisor [3:0], polarity [4], phase [5], decoder mode [6], select code [10:7] |
| dly_we | input | 1 | Load strobe for `dly_word` |
| dly_word | input | 32 | Lead [7:0], trail [15:8], device-change gap [23:16], rest [31:24] |
| xfer_start | input | 1 | One-cycle transfer request |
| xfer_bits | input | 8 | Number of serial clock cycles in the transfer |
| sclk | output | 1 | Serial clock |
| csn | output | 4 | Active-low select lines or decoder code |
| busy | output | 1 | High from acceptance of a start until the rest interval ends |
| idle | output | 1 | Inverse of `busy` |

## Verification
Transfers are run in all four polarity and phase combinations, with divisors of 0, 1, 2, 3, 4 and 15. These runs separate the phase-dependent lead and trail offsets from the divisor-dependent spacing. Delay words of all zeros and all 255s exercise the ends of the counters. Repeated and changing select patterns show whether the device-change gap is added only on a change. Direct and decoder modes show the two select encodings apart. Writes while enabled, starts while busy, starts while disabled and a zero bit count each check that an ignored request leaves the waveform and `busy` untouched.

// File: rtl/qfs_pkg.sv
`timescale 1ns/1ps
package qfs_pkg;
   typedef enum logic [2:0] {
      ST_IDLE  = 3'd0,
      ST_LEAD  = 3'd1,
      ST_SHIFT = 3'd2,
      ST_TRAIL = 3'd3,
      ST_GAP   = 3'd4
   } qfs_state_e;
endpackage

// File: rtl/qfs_cfg_regs.sv
`timescale 1ns/1ps
// Holds the clock/select setup and the four interval counts.
// Both words load only while the global enable is low.
module qfs_cfg_regs #(
   parameter int DIV_W = 4,
   parameter int DLY_W = 8,
   parameter int CS_W  = 4,
   localparam int CFG_W = DIV_W + 3 + CS_W
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               en,
   input  logic               cfg_we,
   input  logic [CFG_W-1:0]   cfg_word,
   input  logic               dly_we,
   input  logic [4*DLY_W-1:0] dly_word,
   output logic [DIV_W-1:0]   div,
   output logic               cpol,
   output logic               cpha,
   output logic               dec,
   output logic [CS_W-1:0]    sel,
   output logic [DLY_W-1:0]   lead_cnt,
   output logic [DLY_W-1:0]   trail_cnt,
   output logic [DLY_W-1:0]   swap_cnt,
   output logic [DLY_W-1:0]   rest_cnt
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         div  <= '0;
         cpol <= 1'b0;
         cpha <= 1'b0;
         dec  <= 1'b0;
         sel  <= '0;
      end else if (cfg_we && !en) begin
         {sel, dec, cpha, cpol, div} <= cfg_word;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lead_cnt  <= '0;
         trail_cnt <= '0;
         swap_cnt  <= '0;
         rest_cnt  <= '0;
      end else if (dly_we && !en) begin
         {rest_cnt, swap_cnt, trail_cnt, lead_cnt} <= dly_word;
      end
   end
endmodule

// File: rtl/qfs_sel_map.sv
`timescale 1ns/1ps
// Turns the select code into the pin pattern: raw code for an external
// decoder, or one low line per device.
module qfs_sel_map #(
   parameter int CS_W = 4,
   localparam int IDX_W = (CS_W > 1) ? $clog2(CS_W) : 1
) (
   input  logic            dec,
   input  logic [CS_W-1:0] sel,
   output logic [CS_W-1:0] pat
);
   logic [CS_W-1:0] one_cold;

   for (genvar gi = 0; gi < CS_W; gi++) begin : g_line
      assign one_cold[gi] = (sel[IDX_W-1:0] != IDX_W'(gi));
   end

   assign pat = dec ? sel : one_cold;
endmodule

// File: rtl/qfs_sclk_gen.sv
`timescale 1ns/1ps
// Half-period divider and edge placement for the serial clock.
module qfs_sclk_gen #(
   parameter int DIV_W = 4,
   parameter int NB_W  = 8,
   localparam int HC_W = NB_W + 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             go,
   input  logic [NB_W-1:0]  bits,
   input  logic [DIV_W-1:0] div,
   input  logic             cpol,
   input  logic             cpha,
   output logic             sclk,
   output logic             last_end
);
   logic             active;
   logic [DIV_W-1:0] sub;
   logic [HC_W-1:0]  hidx;
   logic [HC_W-1:0]  hlast;
   logic             lvl;

   assign hlast    = {bits, 1'b0} - HC_W'(1);
   assign last_end = active && (sub == '0) && (hidx == hlast);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active <= 1'b0;
         sub    <= '0;
         hidx   <= '0;
         lvl    <= 1'b0;
      end else if (go) begin
         active <= 1'b1;
         sub    <= div;
         hidx   <= '0;
         lvl    <= cpha ? ~cpol : cpol;
      end else if (active) begin
         if (sub == '0) begin
            if (last_end) begin
               active <= 1'b0;
            end else begin
               hidx <= hidx + HC_W'(1);
               sub  <= div;
            end
            // phase 1 places no edge at the end of the final half period
            if (!(last_end && cpha)) lvl <= ~lvl;
         end else begin
            sub <= sub - DIV_W'(1);
         end
      end
   end

   assign sclk = active ? lvl : cpol;
endmodule

// File: rtl/qfs_seq.sv
`timescale 1ns/1ps
// Transfer sequencer: lead, clocking, trail and rest intervals.
module qfs_seq
   import qfs_pkg::*;
#(
   parameter int DIV_W = 4,
   parameter int DLY_W = 8,
   parameter int CS_W  = 4,
   parameter int NB_W  = 8,
   parameter int TMR_W = 10
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic             start,
   input  logic [NB_W-1:0]  bits,
   input  logic [DIV_W-1:0] div,
   input  logic [DLY_W-1:0] lead_cnt,
   input  logic [DLY_W-1:0] trail_cnt,
   input  logic [DLY_W-1:0] swap_cnt,
   input  logic [DLY_W-1:0] rest_cnt,
   input  logic [CS_W-1:0]  pat,
   input  logic             shift_last,
   output logic             shift_go,
   output logic [NB_W-1:0]  bits_q,
   output logic [CS_W-1:0]  csn,
   output logic             busy
);
   qfs_state_e       state, nxt;
   logic [TMR_W-1:0] tmr, tmr_nxt;
   logic [TMR_W-1:0] twoh;
   logic [CS_W-1:0]  pat_q, prev_pat, pat_use;
   logic             prev_vld;
   logic             accept, tmr_zero, swap, sel_low;

   assign twoh     = TMR_W'({div, 1'b0}) + TMR_W'(2);
   assign accept   = (state == ST_IDLE) && en && start && (bits != '0);
   assign tmr_zero = (tmr == '0);
   assign shift_go = (state == ST_LEAD) && tmr_zero;
   assign swap     = prev_vld && (prev_pat != pat_q);
   assign pat_use  = accept ? pat : pat_q;

   always_comb begin
      nxt     = state;
      tmr_nxt = tmr_zero ? '0 : tmr - TMR_W'(1);
      unique case (state)
         ST_IDLE: if (accept) begin
            nxt     = ST_LEAD;
            tmr_nxt = TMR_W'(lead_cnt);
         end
         ST_LEAD: if (tmr_zero) nxt = ST_SHIFT;
         ST_SHIFT: if (shift_last) begin
            nxt     = ST_TRAIL;
            tmr_nxt = TMR_W'(trail_cnt) + twoh + TMR_W'(2);
         end
         ST_TRAIL: if (tmr_zero) begin
            nxt     = ST_GAP;
            tmr_nxt = TMR_W'(rest_cnt) + twoh + (swap ? TMR_W'(swap_cnt) : '0);
         end
         ST_GAP: if (tmr_zero) nxt = ST_IDLE;
         default: nxt = ST_IDLE;
      endcase
   end

   assign sel_low = (nxt == ST_LEAD) || (nxt == ST_SHIFT) || (nxt == ST_TRAIL);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= ST_IDLE;
         tmr      <= '0;
         bits_q   <= '0;
         pat_q    <= '1;
         prev_pat <= '1;
         prev_vld <= 1'b0;
         csn      <= '1;
         busy     <= 1'b0;
      end else begin
         state <= nxt;
         tmr   <= tmr_nxt;
         if (accept) begin
            bits_q <= bits;
            pat_q  <= pat;
         end
         if ((state == ST_TRAIL) && tmr_zero) begin
            prev_pat <= pat_q;
            prev_vld <= 1'b1;
         end
         csn  <= sel_low ? pat_use : '1;
         busy <= (nxt != ST_IDLE);
      end
   end
endmodule

// File: rtl/sflash_strobe_gen.sv
`timescale 1ns/1ps
module sflash_strobe_gen #(
   parameter int DIV_W = 4,
   parameter int DLY_W = 8,
   parameter int CS_W  = 4,
   parameter int NB_W  = 8,
   localparam int CFG_W  = DIV_W + 3 + CS_W,
   localparam int HALF_W = DIV_W + 1,
   localparam int TMR_W  = ((DLY_W > HALF_W + 1) ? DLY_W : HALF_W + 1) + 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               ctl_en,
   input  logic               cfg_we,
   input  logic [CFG_W-1:0]   cfg_word,
   input  logic               dly_we,
   input  logic [4*DLY_W-1:0] dly_word,
   input  logic               xfer_start,
   input  logic [NB_W-1:0]    xfer_bits,
   output logic               sclk,
   output logic [CS_W-1:0]    csn,
   output logic               busy,
   output logic               idle
);
   if (DIV_W < 1 || DIV_W > 8) begin : g_bad_div
      $error("DIV_W must lie in 1..8");
   end
   if (CS_W < 2) begin : g_bad_cs
      $error("CS_W must be at least 2");
   end
   if (NB_W < 1 || DLY_W < 1) begin : g_bad_cnt
      $error("NB_W and DLY_W must be positive");
   end

   logic [DIV_W-1:0] cfg_div;
   logic             cfg_cpol, cfg_cpha, cfg_dec;
   logic [CS_W-1:0]  cfg_sel, sel_pat;
   logic [DLY_W-1:0] lead_cnt, trail_cnt, swap_cnt, rest_cnt;
   logic [NB_W-1:0]  bits_q;
   logic             shift_go, shift_last;

   qfs_cfg_regs #(.DIV_W(DIV_W), .DLY_W(DLY_W), .CS_W(CS_W)) i_regs (
      .clk(clk), .rst_n(rst_n), .en(ctl_en),
      .cfg_we(cfg_we), .cfg_word(cfg_word),
      .dly_we(dly_we), .dly_word(dly_word),
      .div(cfg_div), .cpol(cfg_cpol), .cpha(cfg_cpha), .dec(cfg_dec), .sel(cfg_sel),
      .lead_cnt(lead_cnt), .trail_cnt(trail_cnt), .swap_cnt(swap_cnt), .rest_cnt(rest_cnt)
   );

   qfs_sel_map #(.CS_W(CS_W)) i_map (
      .dec(cfg_dec), .sel(cfg_sel), .pat(sel_pat)
   );

   qfs_seq #(.DIV_W(DIV_W), .DLY_W(DLY_W), .CS_W(CS_W), .NB_W(NB_W), .TMR_W(TMR_W)) i_seq (
      .clk(clk), .rst_n(rst_n), .en(ctl_en), .start(xfer_start), .bits(xfer_bits),
      .div(cfg_div), .lead_cnt(lead_cnt), .trail_cnt(trail_cnt),
      .swap_cnt(swap_cnt), .rest_cnt(rest_cnt), .pat(sel_pat),
      .shift_last(shift_last), .shift_go(shift_go), .bits_q(bits_q),
      .csn(csn), .busy(busy)
   );

   qfs_sclk_gen #(.DIV_W(DIV_W), .NB_W(NB_W)) i_clk (
      .clk(clk), .rst_n(rst_n), .go(shift_go), .bits(bits_q),
      .div(cfg_div), .cpol(cfg_cpol), .cpha(cfg_cpha),
      .sclk(sclk), .last_end(shift_last)
   );

   assign idle = ~busy;
endmodule

// File: rtl/qfs_checker.sv
`timescale 1ns/1ps
module qfs_checker #(
   parameter int CS_W  = 4,
   parameter int DIV_W = 4
) (
   input logic             clk,
   input logic             rst_n,
   input logic             ctl_en,
   input logic             xfer_start,
   input logic             busy,
   input logic             sclk,
   input logic [CS_W-1:0]  csn,
   input logic             cpol,
   input logic             dec,
   input logic [DIV_W-1:0] div
);
   a_r2_idle_level: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> sclk == cpol);

   a_r4_one_cold: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !dec && csn != '1) |-> $countones(csn) == CS_W - 1);

   a_r10_start_gate: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> ($past(xfer_start) && $past(ctl_en)));

   a_r9_cfg_locked: assert property (@(posedge clk) disable iff (!rst_n)
      ctl_en |=> ($stable(div) && $stable(cpol) && $stable(dec)));
endmodule

bind sflash_strobe_gen qfs_checker #(.CS_W(CS_W), .DIV_W(DIV_W)) i_chk (
   .clk(clk), .rst_n(rst_n), .ctl_en(ctl_en), .xfer_start(xfer_start),
   .busy(busy), .sclk(sclk), .csn(csn),
   .cpol(cfg_cpol), .dec(cfg_dec), .div(cfg_div)
);

// File: tb/test_sflash_strobe_gen.sv
`timescale 1ns/1ps
module test_sflash_strobe_gen;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ctl_en = 1'b0, cfg_we = 1'b0, dly_we = 1'b0, xfer_start = 1'b0;
   logic [10:0] cfg_word = '0;
   logic [31:0] dly_word = '0;
   logic [7:0]  xfer_bits = '0;
   logic        sclk, busy, idle;
   logic [3:0]  csn;

   always #2.5 clk = ~clk;

   sflash_strobe_gen i_sflash_strobe_gen (
      .clk(clk), .rst_n(rst_n), .ctl_en(ctl_en), .cfg_we(cfg_we), .cfg_word(cfg_word),
      .dly_we(dly_we), .dly_word(dly_word), .xfer_start(xfer_start), .xfer_bits(xfer_bits),
      .sclk(sclk), .csn(csn), .busy(busy), .idle(idle)
   );

   int cyc = 0;
   always @(posedge clk) cyc <= cyc + 1;

   int n_chk = 0, n_err = 0;
   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   typedef struct {
      int lead; int half; int toggles; int trail; int gap;
      logic [3:0] pat; logic pol; string pat_req; string gap_req;
   } exp_t;
   exp_t exq[$];

   // model of the programmed setup
   int m_div = 0, m_lead = 0, m_trail = 0, m_swap = 0, m_rest = 0;
   bit m_cpol = 0, m_cpha = 0, m_dec = 0;
   logic [3:0] m_sel = '0, prev_pat = '1;
   bit prev_vld = 0;

   task automatic set_cfg(input int dv, input bit pol, input bit pha, input bit dc, input logic [3:0] s);
      @(negedge clk);
      ctl_en = 1'b0; cfg_word = {s, dc, pha, pol, 4'(dv)}; cfg_we = 1'b1;
      @(negedge clk);
      cfg_we = 1'b0; ctl_en = 1'b1;
      m_div = dv; m_cpol = pol; m_cpha = pha; m_dec = dc; m_sel = s;
   endtask

   task automatic set_dly(input int ld, input int tr, input int sw, input int rs);
      @(negedge clk);
      ctl_en = 1'b0; dly_word = {8'(rs), 8'(sw), 8'(tr), 8'(ld)}; dly_we = 1'b1;
      @(negedge clk);
      dly_we = 1'b0; ctl_en = 1'b1;
      m_lead = ld; m_trail = tr; m_swap = sw; m_rest = rs;
   endtask

   // driver: predicts the waveform timing and pushes it to the scoreboard
   task automatic xfer(input int n, input bit retrig);
      exp_t e;
      int h;
      h = m_div + 1;
      e.pat     = m_dec ? m_sel : ~(4'b0001 << m_sel[1:0]);
      e.pat_req = m_dec ? "R5" : "R4";
      e.half    = h;
      e.toggles = 2 * n;
      e.pol     = m_cpol;
      e.lead    = m_lead + 1 + (m_cpha ? 0 : h);
      e.trail   = m_trail + 2*h + 3 + (m_cpha ? h : 0);
      if (prev_vld && prev_pat != e.pat) begin
         e.gap = m_rest + 2*h + 1 + m_swap; e.gap_req = "R8";
      end else begin
         e.gap = m_rest + 2*h + 1; e.gap_req = "R7";
      end
      prev_pat = e.pat; prev_vld = 1;
      exq.push_back(e);
      @(negedge clk);
      xfer_start = 1'b1; xfer_bits = 8'(n);
      @(negedge clk);
      xfer_start = 1'b0;
      if (retrig) begin
         repeat (3) @(negedge clk);
         xfer_start = 1'b1; xfer_bits = 8'd5;
         @(negedge clk);
         xfer_start = 1'b0;
      end
      while (busy) @(negedge clk);
      repeat (2) @(negedge clk);
   endtask

   // monitor: measures each transfer and compares with the queued prediction
   bit in_x = 0, csn_up = 0;
   int t_rise, t_first, t_last, t_up, ntog, bad_sp, meas_half;
   logic prev_sclk = 1'b0, prev_busy = 1'b0;
   logic [3:0] pat_seen;

   always @(negedge clk) begin
      if (rst_n) begin
         if (busy && !prev_busy) begin
            in_x = 1; t_rise = cyc; ntog = 0; bad_sp = 0; csn_up = 0; pat_seen = csn; meas_half = 0;
         end else if (in_x) begin
            if (sclk !== prev_sclk) begin
               if (ntog == 0) t_first = cyc;
               else begin
                  if (ntog == 1) meas_half = cyc - t_last;
                  if (exq.size() > 0 && (cyc - t_last) != exq[0].half) bad_sp++;
               end
               t_last = cyc; ntog++;
            end
            if (!csn_up && csn == 4'hF) begin csn_up = 1; t_up = cyc; end
            if (!busy) begin
               in_x = 0;
               if (exq.size() == 0) check(0, "R10", 1, 0);
               else begin
                  exp_t e;
                  e = exq.pop_front();
                  check(pat_seen == e.pat, e.pat_req, int'(pat_seen), int'(e.pat));
                  check((t_first - t_rise) == e.lead, "R3", t_first - t_rise, e.lead);
                  check(bad_sp == 0, "R1", bad_sp, 0);
                  check(ntog == e.toggles, "R2", ntog, e.toggles);
                  check(sclk == e.pol, "R2", int'(sclk), int'(e.pol));
                  check((t_up - t_last) == e.trail, "R6", t_up - t_last, e.trail);
                  check((cyc - t_up) == e.gap, e.gap_req, cyc - t_up, e.gap);
               end
            end
         end
      end
      prev_sclk = sclk; prev_busy = busy;
   end

   task automatic report;
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_err++;
      $display("FAIL R10 watchdog actual=running expected=done");
      report();
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      // R11 reset state
      check(csn == 4'hF, "R11", int'(csn), 15);
      check(busy == 1'b0, "R11", int'(busy), 0);
      check(idle == 1'b1, "R11", int'(idle), 1);
      check(sclk == 1'b0, "R11", int'(sclk), 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      set_cfg(0, 0, 0, 0, 4'd0); set_dly(2, 1, 5, 3);
      xfer(3, 0);                                   // first transfer: no gap (R7)
      set_cfg(2, 0, 1, 0, 4'd0); xfer(2, 0);        // same device again (R7)
      set_cfg(1, 1, 0, 0, 4'd2); xfer(4, 0);        // device change (R8), 1011 (R4)
      set_cfg(15, 1, 1, 1, 4'b0101); set_dly(0, 0, 0, 0);
      xfer(1, 0);                                   // decoder code (R5)
      set_dly(255, 255, 255, 255); set_cfg(3, 0, 0, 0, 4'd3);
      xfer(2, 0);                                   // counter ends, device change (R8)

      // R9: write while enabled must not change the divisor
      set_cfg(4, 0, 1, 0, 4'd1); set_dly(1, 2, 3, 4);
      @(negedge clk);
      ctl_en = 1'b1; cfg_word = {4'd1, 1'b0, 1'b0, 1'b1, 4'd9}; cfg_we = 1'b1;
      @(negedge clk);
      cfg_we = 1'b0;
      xfer(3, 0);
      check(meas_half == 5, "R9", meas_half, 5);

      // R10: start while busy ignored; scoreboard would see extra toggles
      set_cfg(0, 1, 0, 0, 4'd1); xfer(2, 1);
      check(busy == 1'b0, "R10", int'(busy), 0);

      // R10: start while disabled ignored
      @(negedge clk);
      ctl_en = 1'b0; xfer_start = 1'b1; xfer_bits = 8'd2;
      @(negedge clk);
      xfer_start = 1'b0;
      for (int i = 0; i < 4; i++) begin
         @(negedge clk);
         check(busy == 1'b0, "R10", int'(busy), 0);
      end
      // R10: zero bit count ignored
      ctl_en = 1'b1; xfer_start = 1'b1; xfer_bits = 8'd0;
      @(negedge clk);
      xfer_start = 1'b0;
      for (int i = 0; i < 4; i++) begin
         @(negedge clk);
         check(busy == 1'b0 && idle == 1'b1, "R10", int'(busy), 0);
      end
      check(sclk == 1'b1, "R2", int'(sclk), 1);
      check(exq.size() == 0, "R10", exq.size(), 0);
      report();
      $finish;
   end
endmodule